// File: doc/BRIEF.md
# Flagged Ripple-Carry Arithmetic Unit

This block is the arithmetic core of a small processor datapath. It takes two operands, a three-bit operation code and an external carry bit. It returns the arithmetic result together with four condition flags: zero, carry, overflow and sign. It is purely combinational. A result and its flags follow any change at the inputs within the same cycle, after the delay of the carry chain.

Every operation passes through one shared ripple-carry adder, which is built from identical one-bit full adder cells. A small decoder turns the operation code into a packed bundle of select strobes. One strobe picks the true or inverted first operand. Another picks the true, inverted or zeroed second operand. The third picks the adder's carry-in: zero, one, or the external carry. The flags come from the adder's own carries and from the finished result.

Top module: `arith_unit`

## Requirements
- R1: The adder is a chain of one-bit full adder cells with each carry-out feeding the next carry-in; its sum and final carry equal the arithmetic sum of its two inputs and its carry-in.
- R2: Code 3'b001 gives result = x + y; the external carry bit has no effect.
- R3: Code 3'b010 gives result = x + ~y + 1 (x minus y); the carry flag is 1 exactly when x >= y unsigned, e.g. 1 - 2 gives 8'hFF with carry 0, sign 1, overflow 0.
- R4: Code 3'b011 gives result = x + y + carryIn.
- R5: Code 3'b100 gives result = ~x + 1 (two's complement of x); y and the external carry have no effect, and the carry flag is 1 only when x is zero.
- R6: Code 3'b101 gives result = x + 1; y and the external carry have no effect.
- R7: Codes 3'b000, 3'b110 and 3'b111 return x unchanged with carry and overflow flags at 0, whatever y and the external carry are.
- R8: The zero flag is 1 exactly when all result bits are 0.
- R9: The carry flag is the carry out of the most significant adder bit.
- R10: The overflow flag is the XOR of the carries out of the two most significant adder bits; e.g. 8'h01 + 8'h7F gives 8'h80 with overflow 1.
- R11: The sign flag equals the most significant result bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First operand (x) |
| opB | input | 8 | Second operand (y) |
| opCode | input | 3 | Operation select |
| carryIn | input | 1 | External carry used by add-with-carry |
| result | output | 8 | Arithmetic result |
| zeroFlag | output | 1 | Result is all zeros |
| carryFlag | output | 1 | Carry out of the top bit |
| ovfFlag | output | 1 | Signed overflow |
| signFlag | output | 1 | Top bit of the result |

## Verification
The bench aims at the carry boundaries. It adds 8'h01 to 8'h7F to reach the signed limit, adds 8'hFF to 8'h02 to wrap the unsigned range, subtracts a larger value from a smaller one, negates zero and 8'h80, and increments 8'hFF. If a design took overflow from the wrong pair of carries, or left out the chain's carry-in, the flags would go wrong on exactly these vectors. For the codes that should ignore an input, the bench toggles y and the external carry. A decoder that leaked one of them into add, increment, negate or the pass-through codes would then change the result or the carry flag. Pseudo-random operands over all eight codes cover the remaining flag combinations.

// File: rtl/au_pkg.sv
package au_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS0 = 3'b000,
    OP_ADD   = 3'b001,
    OP_SUB   = 3'b010,
    OP_ADC   = 3'b011,
    OP_NEG   = 3'b100,
    OP_INC   = 3'b101,
    OP_PASS6 = 3'b110,
    OP_PASS7 = 3'b111
  } auOp_e;

  typedef enum logic {X_TRUE = 1'b0, X_INV = 1'b1} xSel_e;
  typedef enum logic [1:0] {Y_TRUE = 2'd0, Y_INV = 2'd1, Y_ZERO = 2'd2} ySel_e;
  typedef enum logic [1:0] {C_ZERO = 2'd0, C_ONE = 2'd1, C_EXT = 2'd2} cSel_e;

  typedef struct packed {
    xSel_e xSel;
    ySel_e ySel;
    cSel_e cSel;
  } auCtrl_t;
endpackage

// File: rtl/au_full_adder.sv
module au_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic halfSum;
  assign halfSum = a ^ b;
  assign s       = halfSum ^ ci;
  assign co      = (a & b) | (halfSum & ci);
endmodule

// File: rtl/au_ripple_adder.sv
module au_ripple_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             coutTop,
  output logic             coutBelow
);
  logic [WIDTH:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    au_full_adder u_fa (
      .a  (a[i]),
      .b  (b[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign coutTop   = chain[WIDTH];
  assign coutBelow = chain[WIDTH-1];

  always_comb begin
    p_sum_r1: assert ({coutTop, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci}))
      else $error("R1: ripple chain sum differs from arithmetic sum");
  end
endmodule

// File: rtl/au_ctrl.sv
module au_ctrl
  import au_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output auCtrl_t         ctrl
);
  always_comb begin
    ctrl = '{xSel: X_TRUE, ySel: Y_ZERO, cSel: C_ZERO};
    case (opCode)
      OP_ADD: ctrl = '{xSel: X_TRUE, ySel: Y_TRUE, cSel: C_ZERO};
      OP_SUB: ctrl = '{xSel: X_TRUE, ySel: Y_INV,  cSel: C_ONE};
      OP_ADC: ctrl = '{xSel: X_TRUE, ySel: Y_TRUE, cSel: C_EXT};
      OP_NEG: ctrl = '{xSel: X_INV,  ySel: Y_ZERO, cSel: C_ONE};
      OP_INC: ctrl = '{xSel: X_TRUE, ySel: Y_ZERO, cSel: C_ONE};
      default: ctrl = '{xSel: X_TRUE, ySel: Y_ZERO, cSel: C_ZERO};
    endcase
  end
endmodule

// File: rtl/au_datapath.sv
module au_datapath
  import au_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  auCtrl_t          ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryFlag,
  output logic             ovfFlag,
  output logic             signFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addA, addB;
  logic             addC, coutTop, coutBelow;

  always_comb begin
    addA = (ctrl.xSel == X_INV) ? ~opA : opA;
    case (ctrl.ySel)
      Y_TRUE:  addB = opB;
      Y_INV:   addB = ~opB;
      default: addB = '0;
    endcase
    case (ctrl.cSel)
      C_ONE:   addC = 1'b1;
      C_EXT:   addC = carryIn;
      default: addC = 1'b0;
    endcase
  end

  au_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .a         (addA),
    .b         (addB),
    .ci        (addC),
    .sum       (result),
    .coutTop   (coutTop),
    .coutBelow (coutBelow)
  );

  assign zeroFlag  = ~(|result);
  assign carryFlag = coutTop;
  assign ovfFlag   = coutTop ^ coutBelow;
  assign signFlag  = result[MSB];

  always_comb begin
    p_ovf_r10: assert (ovfFlag == ((addA[MSB] == addB[MSB]) && (result[MSB] != addA[MSB])))
      else $error("R10: overflow flag disagrees with operand/result signs");
    if (ctrl.xSel == X_TRUE && ctrl.ySel == Y_INV && ctrl.cSel == C_ONE) begin
      p_sub_r3: assert (result == WIDTH'(opA - opB) && carryFlag == (opA >= opB))
        else $error("R3: subtract result or borrow wrong");
    end
    if (ctrl.xSel == X_INV && ctrl.ySel == Y_ZERO && ctrl.cSel == C_ONE) begin
      p_neg_r5: assert (result == WIDTH'(-opA) && carryFlag == (opA == '0))
        else $error("R5: negate result wrong");
    end
    if (ctrl.xSel == X_TRUE && ctrl.ySel == Y_ZERO && ctrl.cSel == C_ONE) begin
      p_inc_r6: assert (result == WIDTH'(opA + 1'b1))
        else $error("R6: increment result wrong");
    end
    if (ctrl.xSel == X_TRUE && ctrl.ySel == Y_ZERO && ctrl.cSel == C_ZERO) begin
      p_pass_r7: assert (result == opA && !carryFlag && !ovfFlag)
        else $error("R7: pass-through altered x or raised a flag");
    end
  end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import au_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [OP_W-1:0]  opCode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryFlag,
  output logic             ovfFlag,
  output logic             signFlag
);
  auCtrl_t ctrl;

  au_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  au_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .ctrl      (ctrl),
    .result    (result),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag),
    .signFlag  (signFlag)
  );
endmodule

// File: tb/arith_unit_tb.sv
module arith_unit_tb;
  logic       clk = 1'b0;
  logic [7:0] opA = '0, opB = '0;
  logic [2:0] opCode = '0;
  logic       carryIn = 1'b0;
  logic [7:0] result;
  logic       zeroFlag, carryFlag, ovfFlag, signFlag;

  int nCompared = 0;
  int nMismatch = 0;
  bit finished  = 1'b0;

  always #4 clk = ~clk;

  arith_unit u_dut (
    .opA(opA), .opB(opB), .opCode(opCode), .carryIn(carryIn),
    .result(result), .zeroFlag(zeroFlag), .carryFlag(carryFlag),
    .ovfFlag(ovfFlag), .signFlag(signFlag)
  );

  task automatic check(input string tag, input int actual, input int expected);
    nCompared++;
    if (actual != expected) begin
      nMismatch++;
      $display("FAIL %s actual=%0h expected=%0h (op=%0b a=%0h b=%0h cin=%0b)",
               tag, actual, expected, opCode, opA, opB, carryIn);
    end
  endtask

  // Behavioural reference: integer arithmetic per operation.
  task automatic apply(input logic [7:0] x, input logic [7:0] y,
                       input logic [2:0] op, input logic ci);
    int tx, ty, tc, full, low7, expRes, expC, expV;
    string opTag;
    @(posedge clk);
    opA = x; opB = y; opCode = op; carryIn = ci;
    case (op)
      3'b001: begin tx = x;       ty = y;       tc = 0;  opTag = "R2"; end
      3'b010: begin tx = x;       ty = 255 - y; tc = 1;  opTag = "R3"; end
      3'b011: begin tx = x;       ty = y;       tc = ci; opTag = "R4"; end
      3'b100: begin tx = 255 - x; ty = 0;       tc = 1;  opTag = "R5"; end
      3'b101: begin tx = x;       ty = 0;       tc = 1;  opTag = "R6"; end
      default: begin tx = x;      ty = 0;       tc = 0;  opTag = "R7"; end
    endcase
    full   = tx + ty + tc;
    expRes = full % 256;
    expC   = full / 256;
    low7   = ((tx % 128) + (ty % 128) + tc) / 128;
    expV   = low7 ^ expC;
    @(negedge clk);
    check({opTag, " R1 result"}, result, expRes);
    check("R8 zero", zeroFlag, (expRes == 0) ? 1 : 0);
    check("R9 carry", carryFlag, expC);
    check("R10 overflow", ovfFlag, expV);
    check("R11 sign", signFlag, expRes / 128);
    if (op == 3'b010) check("R3 carry-no-borrow", carryFlag, (x >= y) ? 1 : 0);
    if (op == 3'b100) check("R5 carry-only-zero", carryFlag, (x == 0) ? 1 : 0);
    if (op == 3'b000 || op == 3'b110 || op == 3'b111) begin
      check("R7 pass x", result, x);
      check("R7 carry0", carryFlag, 0);
      check("R7 ovf0", ovfFlag, 0);
    end
  endtask

  initial begin
    // Idle inputs: all zero selects pass of x=0.
    @(negedge clk);
    check("R8 idle zero", zeroFlag, 1);
    check("R7 idle result", result, 0);

    // Named corner vectors
    apply(8'h01, 8'h7F, 3'b001, 1'b0);
    check("R10 01+7F ovf", ovfFlag, 1);
    check("R2 01+7F", result, 8'h80);
    apply(8'hFF, 8'h02, 3'b001, 1'b0);
    check("R9 FF+02 carry", carryFlag, 1);
    apply(8'h01, 8'h02, 3'b010, 1'b0);
    check("R3 1-2", result, 8'hFF);
    check("R3 1-2 sign", signFlag, 1);
    check("R3 1-2 ovf", ovfFlag, 0);
    check("R3 1-2 carry", carryFlag, 0);
    apply(8'h80, 8'h01, 3'b010, 1'b0);
    apply(8'h55, 8'h55, 3'b010, 1'b1);
    check("R8 equal sub zero", zeroFlag, 1);
    apply(8'hFF, 8'h00, 3'b011, 1'b1);
    check("R4 FF+0+1", result, 8'h00);
    apply(8'h7F, 8'h00, 3'b011, 1'b1);
    check("R4 7F+0+1 ovf", ovfFlag, 1);
    apply(8'h00, 8'h33, 3'b100, 1'b1);
    apply(8'h80, 8'h00, 3'b100, 1'b0);
    check("R5 neg 80 ovf", ovfFlag, 1);
    apply(8'hFF, 8'hAA, 3'b101, 1'b1);
    check("R6 inc FF", result, 8'h00);
    apply(8'h7F, 8'h00, 3'b101, 1'b0);

    // Ignored inputs: toggle y and carry on codes that must not use them
    for (int op = 0; op < 8; op++) begin
      if (op == 2 || op == 3) continue;
      apply(8'h3C, 8'h00, 3'(op), 1'b0);
      apply(8'h3C, 8'hFF, 3'(op), 1'b1);
      apply(8'hC3, 8'h5A, 3'(op), 1'b1);
    end
    for (int op = 2; op < 4; op++) begin
      apply(8'hA5, 8'h5A, 3'(op), 1'b0);
      apply(8'hA5, 8'h5A, 3'(op), 1'b1);
    end

    // Pseudo-random sweep across all codes
    for (int i = 0; i < 2000; i++) begin
      apply(8'($urandom), 8'($urandom), 3'(i % 8), 1'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end
endmodule